// File: doc/BRIEF.md
# Interlaced CCD Vertical Timing Generator

This block produces the line-rate and field-rate control signals that an interlaced CCD sensor needs. It counts sensor lines, starting each field at line 1, and moves through an odd field and an even field in turn. Each field has its own length, its own end for the vertical reference window and its own charge-transfer line. On the transfer line the four vertical clock phases change from the normal line pattern to a readout pattern, and two extra readout pulses are enabled. The block also drives a programmable overflow-drain marker line and the pair of horizontal shift clocks, which are gated by a horizontal blanking input.

Software programs the limits through a byte-wide write port. Every write goes to a shadow copy first. The shadow copy moves into the working set only at a field boundary, so a field in progress never sees its limits change. A line begins at each rising edge of the line-start strobe, and that strobe is sampled on the block clock.

Top module: `ccd_vtiming_gen`

## Requirements
- R1: The write port map is as follows. Addresses 0 to 6 hold the low 8 bits of these values, in this order: odd-field line count, even-field line count, odd reference end, even reference end, odd transfer line, even transfer line, overflow-drain line. Bit k of address 7 supplies bit 8 of the value at address k, for k from 0 to 6. Writes to addresses 8 and above change nothing.
- R2: A write reaches the shadow copy at the clock edge where wr_en is sampled high. The shadow set is copied into the working set at the field boundary edge, which is the edge that returns to line 1. Until that edge, the field in progress keeps its old limits, and this includes the drain line.
- R3: A line advances at the clock edge where line_strobe is sampled high after being sampled low in the previous cycle. Holding the strobe high for several cycles advances only one line.
- R4: fld is 0 for the odd field and 1 for the even field. A field whose count is N advances through lines 1 to N. On the next line advance it toggles fld and returns to line 1. A count of 0 behaves like a count of 1.
- R5: vref is high while the current line number is less than or equal to the current field's reference end. An end value of 0 keeps vref low for the whole field.
- R6: xfer_line is high exactly during the line whose number equals the current field's transfer line.
- R7: A 2-bit step is 0 after the edge that starts a line and increases by 1 modulo 4 on every other edge. Outside the transfer line, vclk is 4'b0011, 4'b0110, 4'b1100 or 4'b1001 for step 0, 1, 2 or 3, and rd_pulse is 0.
- R8: On the transfer line, vclk is 4'b0001 shifted left by the step. rd_pulse[0] is high at step 1 and rd_pulse[1] is high at step 3.
- R9: ofd is high during the line whose number equals the working drain line. A drain line of 0 never asserts ofd.
- R10: h1 is cleared at an edge where hblank is high and inverts at every other edge. h2 is always the inverse of h1.
- R11: After reset the state is as follows. The field is odd, the line is 1 and the step is 0. h1 is 0. Both register sets hold the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the pixel clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 1 | Line-start strobe; a rising edge begins a new line |
| hblank | input | 1 | Horizontal blanking enable; high stops the shift clocks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| fld | output | 1 | Field flag, 0 odd, 1 even |
| vref | output | 1 | Vertical reference window |
| xfer_line | output | 1 | Charge-transfer line marker |
| vclk | output | 4 | Four-phase vertical clock |
| rd_pulse | output | 2 | Extra readout pulses, transfer line only |
| ofd | output | 1 | Overflow-drain line marker |
| h1 | output | 1 | Horizontal shift clock, phase 1 |
| h2 | output | 1 | Horizontal shift clock, phase 2 |

## Verification
A wrong line count or field flag appears at vref, xfer_line and ofd on the first line where the expected and actual line numbers give different decodes. A slipped field boundary shows on fld one line early or late. A working set loaded at the wrong time changes the length of the field that follows, so it shows up at most one field later. A wrong step or a wrong choice of pattern shows on vclk and rd_pulse within one clock. A wrong shift-clock state shows on h1 and h2 at the next edge.

// File: rtl/ccd_vt_pkg.sv
package ccd_vt_pkg;
  // Count of programmable line values held in the register file
  localparam int NPAR = 7;
  // Slot indices, equal to the write addresses of their low bytes
  localparam int S_ODD_LINES = 0;
  localparam int S_EVEN_LINES = 1;
  localparam int S_ODD_VEND = 2;
  localparam int S_EVEN_VEND = 3;
  localparam int S_ODD_XFER = 4;
  localparam int S_EVEN_XFER = 5;
  localparam int S_DRAIN = 6;
  // Number of vertical clock phases
  localparam int NPH = 4;
endpackage

// File: rtl/ccd_vt_regs.sv
module ccd_vt_regs
  import ccd_vt_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [NPAR*LINE_W-1:0] DEF_FLAT = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          load,
  output logic [NPAR-1:0][LINE_W-1:0]   act_par
);
  localparam int HI_W = LINE_W - DATA_W;
  localparam int HIB  = NPAR * HI_W;

  function automatic logic [HIB-1:0] def_hi();
    logic [HIB-1:0] r;
    r = '0;
    for (int k = 0; k < NPAR; k++) begin
      r[k*HI_W +: HI_W] = DEF_FLAT[k*LINE_W+DATA_W +: HI_W];
    end
    return r;
  endfunction

  logic [HIB-1:0] hi_q, hi_d;

  always_comb begin
    hi_d = hi_q;
    if (wr_en && (wr_addr == ADDR_W'(NPAR))) hi_d = wr_data[HIB-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= def_hi();
    else        hi_q <= hi_d;
  end

  for (genvar k = 0; k < NPAR; k++) begin : g_slot
    logic [DATA_W-1:0] lo_q, lo_d;
    logic [LINE_W-1:0] wk_q, wk_d;

    always_comb begin
      lo_d = lo_q;
      if (wr_en && (wr_addr == ADDR_W'(k))) lo_d = wr_data;
      wk_d = wk_q;
      if (load) wk_d = {hi_q[k*HI_W +: HI_W], lo_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= DEF_FLAT[k*LINE_W +: DATA_W];
        wk_q <= DEF_FLAT[k*LINE_W +: LINE_W];
      end else begin
        lo_q <= lo_d;
        wk_q <= wk_d;
      end
    end

    assign act_par[k] = wk_q;
  end

  // Working limits move only on a field boundary
  p_hold_until_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_par));
endmodule

// File: rtl/ccd_vt_linectr.sv
module ccd_vt_linectr #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic [LINE_W-1:0] lines_odd,
  input  logic [LINE_W-1:0] lines_even,
  output logic [LINE_W-1:0] line_cnt,
  output logic              fld,
  output logic              line_edge,
  output logic              load
);
  logic              strobe_q;
  logic [LINE_W-1:0] cnt_q, cnt_d;
  logic              fld_q, fld_d;
  logic [LINE_W-1:0] lim;
  logic              at_last;

  assign line_edge = line_strobe & ~strobe_q;
  assign lim       = fld_q ? lines_even : lines_odd;
  assign at_last   = (cnt_q >= lim);
  assign load      = line_edge & at_last;

  always_comb begin
    cnt_d = cnt_q;
    fld_d = fld_q;
    if (line_edge) begin
      if (at_last) begin
        cnt_d = LINE_W'(1);
        fld_d = ~fld_q;
      end else begin
        cnt_d = cnt_q + LINE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cnt_q    <= LINE_W'(1);
      fld_q    <= 1'b0;
    end else begin
      strobe_q <= line_strobe;
      cnt_q    <= cnt_d;
      fld_q    <= fld_d;
    end
  end

  assign line_cnt = cnt_q;
  assign fld      = fld_q;

  p_field_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fld != $past(fld)) |-> (line_cnt == LINE_W'(1)));
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_edge && !load) |=> (line_cnt == $past(line_cnt) + LINE_W'(1)));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !line_edge |=> ($stable(line_cnt) && $stable(fld)));
endmodule

// File: rtl/ccd_vt_vpattern.sv
module ccd_vt_vpattern
  import ccd_vt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_edge,
  input  logic           xfer,
  output logic [NPH-1:0] vclk,
  output logic [1:0]     rd_pulse
);
  logic [1:0]     step_q, step_d;
  logic [NPH-1:0] norm_pat, read_pat;

  always_comb begin
    step_d = line_edge ? 2'd0 : step_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 2'd0;
    else        step_q <= step_d;
  end

  always_comb begin
    unique case (step_q)
      2'd0: norm_pat = 4'b0011;
      2'd1: norm_pat = 4'b0110;
      2'd2: norm_pat = 4'b1100;
      default: norm_pat = 4'b1001;
    endcase
    read_pat = NPH'(1) << step_q;
  end

  assign vclk     = xfer ? read_pat : norm_pat;
  assign rd_pulse = xfer ? {step_q == 2'd3, step_q == 2'd1} : 2'b00;

  p_step_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_edge |=> (step_q == 2'd0));
  p_rd_in_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse != 2'b00) |-> xfer);
  p_readout_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> $onehot0(vclk) && (vclk != '0));
endmodule

// File: rtl/ccd_vt_hclk.sv
module ccd_vt_hclk (
  input  logic clk,
  input  logic rst_n,
  input  logic hblank,
  output logic h1,
  output logic h2
);
  logic h1_q, h1_d;

  always_comb begin
    h1_d = hblank ? 1'b0 : ~h1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h1_q <= 1'b0;
    else        h1_q <= h1_d;
  end

  assign h1 = h1_q;
  assign h2 = ~h1_q;

  p_blank_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hblank |=> !h1);
  p_run_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hblank |=> (h1 != $past(h1)));
endmodule

// File: rtl/ccd_vtiming_gen.sv
module ccd_vtiming_gen
  import ccd_vt_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [LINE_W-1:0] DEF_ODD_LINES  = 263,
  parameter logic [LINE_W-1:0] DEF_EVEN_LINES = 262,
  parameter logic [LINE_W-1:0] DEF_ODD_VEND   = 18,
  parameter logic [LINE_W-1:0] DEF_EVEN_VEND  = 19,
  parameter logic [LINE_W-1:0] DEF_ODD_XFER   = 20,
  parameter logic [LINE_W-1:0] DEF_EVEN_XFER  = 21,
  parameter logic [LINE_W-1:0] DEF_DRAIN      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe,
  input  logic              hblank,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fld,
  output logic              vref,
  output logic              xfer_line,
  output logic [NPH-1:0]    vclk,
  output logic [1:0]        rd_pulse,
  output logic              ofd,
  output logic              h1,
  output logic              h2
);
  localparam logic [NPAR*LINE_W-1:0] DEF_FLAT = {DEF_DRAIN, DEF_EVEN_XFER, DEF_ODD_XFER,
    DEF_EVEN_VEND, DEF_ODD_VEND, DEF_EVEN_LINES, DEF_ODD_LINES};

  // Asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [NPAR-1:0][LINE_W-1:0] act_par;
  logic [LINE_W-1:0]           line_cnt;
  logic                        fld_i, line_edge, load;
  logic [LINE_W-1:0]           vend_sel, xfer_sel, drain;

  ccd_vt_regs #(
    .LINE_W(LINE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_FLAT(DEF_FLAT)
  ) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .act_par(act_par)
  );

  ccd_vt_linectr #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_i), .line_strobe(line_strobe),
    .lines_odd(act_par[S_ODD_LINES]), .lines_even(act_par[S_EVEN_LINES]),
    .line_cnt(line_cnt), .fld(fld_i), .line_edge(line_edge), .load(load)
  );

  assign vend_sel  = fld_i ? act_par[S_EVEN_VEND] : act_par[S_ODD_VEND];
  assign xfer_sel  = fld_i ? act_par[S_EVEN_XFER] : act_par[S_ODD_XFER];
  assign drain     = act_par[S_DRAIN];
  assign fld       = fld_i;
  assign vref      = (line_cnt <= vend_sel);
  assign xfer_line = (line_cnt == xfer_sel);
  assign ofd       = (drain != '0) && (line_cnt == drain);

  ccd_vt_vpattern u_vpat (
    .clk(clk), .rst_n(rst_i), .line_edge(line_edge), .xfer(xfer_line),
    .vclk(vclk), .rd_pulse(rd_pulse)
  );

  ccd_vt_hclk u_hclk (
    .clk(clk), .rst_n(rst_i), .hblank(hblank), .h1(h1), .h2(h2)
  );

  // A new field with a nonzero window opens with the reference high
  p_window_opens_r5: assert property (@(posedge clk) disable iff (!rst_i)
    ((fld != $past(fld)) && (vend_sel != '0)) |-> vref);
endmodule

// File: tb/ccd_vtiming_gen_test.sv
module ccd_vtiming_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_strobe, hblank, wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       fld, vref, xfer_line, ofd, h1, h2;
  logic [3:0] vclk;
  logic [1:0] rd_pulse;

  localparam int D_ODD_LINES = 263, D_EVEN_LINES = 262, D_ODD_VEND = 18,
                 D_EVEN_VEND = 19, D_ODD_XFER = 20, D_EVEN_XFER = 21, D_DRAIN = 0;

  always #10 clk = ~clk;

  ccd_vtiming_gen #(
    .DEF_ODD_LINES(D_ODD_LINES), .DEF_EVEN_LINES(D_EVEN_LINES),
    .DEF_ODD_VEND(D_ODD_VEND), .DEF_EVEN_VEND(D_EVEN_VEND),
    .DEF_ODD_XFER(D_ODD_XFER), .DEF_EVEN_XFER(D_EVEN_XFER), .DEF_DRAIN(D_DRAIN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .hblank(hblank),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .fld(fld), .vref(vref),
    .xfer_line(xfer_line), .vclk(vclk), .rd_pulse(rd_pulse), .ofd(ofd),
    .h1(h1), .h2(h2)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // Reference model state
  int m_cnt, m_fld, m_step, m_h1, m_prev_s;
  int m_lo[7];
  int m_hi;
  int m_act[7];
  int pq_a[$];
  int pq_d[$];

  function automatic int shd_val(int k);
    return (((m_hi >> k) & 1) << 8) | m_lo[k];
  endfunction

  function automatic int norm_pat(int s);
    case (s)
      0: return 3;
      1: return 6;
      2: return 12;
      default: return 9;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int lines_v, vend, xf;
    bit ex_x;
    vend = m_act[2 + m_fld];
    xf   = m_act[4 + m_fld];
    ex_x = (m_cnt == xf);
    chk("R4", "fld", int'(fld), m_fld);
    chk("R5", "vref", int'(vref), int'(m_cnt <= vend));
    chk("R6", "xfer_line", int'(xfer_line), int'(ex_x));
    chk("R9", "ofd", int'(ofd), int'((m_act[6] != 0) && (m_cnt == m_act[6])));
    if (ex_x) begin
      chk("R8", "vclk readout", int'(vclk), 1 << m_step);
      chk("R8", "rd_pulse", int'(rd_pulse), ((m_step == 3) ? 2 : 0) | ((m_step == 1) ? 1 : 0));
    end else begin
      chk("R7", "vclk normal", int'(vclk), norm_pat(m_step));
      chk("R7", "rd_pulse idle", int'(rd_pulse), 0);
    end
    chk("R10", "h1", int'(h1), m_h1);
    chk("R10", "h2", int'(h2), 1 - m_h1);
    lines_v = 0;
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input bit s, input bit hb, input bit we, input int a, input int d);
    bit rise;
    line_strobe = s; hblank = hb; wr_en = we;
    wr_addr = a[3:0]; wr_data = d[7:0];
    @(posedge clk);
    rise = s && (m_prev_s == 0);
    m_prev_s = s;
    if (rise) begin
      if (m_cnt >= m_act[m_fld]) begin
        m_cnt = 1;
        m_fld = 1 - m_fld;
        for (int k = 0; k < 7; k++) m_act[k] = shd_val(k);
      end else begin
        m_cnt++;
      end
      m_step = 0;
    end else begin
      m_step = (m_step + 1) % 4;
    end
    m_h1 = hb ? 0 : 1 - m_h1;
    if (we) begin
      if (a < 7) m_lo[a] = d & 255;
      else if (a == 7) m_hi = d & 127;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_line();
    int hi_n, len;
    hi_n = 1 + $urandom % 3;
    len  = hi_n + 1 + $urandom % 3;
    for (int i = 0; i < len; i++) begin
      bit hb;
      hb = (($urandom % 3) == 0);
      if (pq_a.size() > 0) cyc(i < hi_n, hb, 1'b1, pq_a.pop_front(), pq_d.pop_front());
      else                 cyc(i < hi_n, hb, 1'b0, 0, 0);
    end
  endtask

  task automatic run_field(output int n);
    int f0;
    f0 = m_fld;
    n = 0;
    while (m_fld == f0 && n < 600) begin
      do_line();
      n++;
    end
  endtask

  task automatic qw(input int a, input int d);
    pq_a.push_back(a);
    pq_d.push_back(d);
  endtask

  task automatic queue_random_cfg();
    int lo, le;
    lo = (($urandom % 8) == 0) ? 0 : 1 + $urandom % 10;
    le = (($urandom % 8) == 0) ? 0 : 1 + $urandom % 10;
    qw(0, lo);
    qw(1, le);
    qw(2, $urandom % (lo + 2));
    qw(3, $urandom % (le + 2));
    qw(4, $urandom % (lo + 2));
    qw(5, $urandom % (le + 2));
    qw(6, $urandom % (lo + 1));
    qw(7, (($urandom % 8) == 0) ? ($urandom % 128) & 7'h7c : 0);
    if (($urandom % 4) == 0) qw(8 + $urandom % 8, $urandom % 256);
  endtask

  initial begin
    int n;
    int defs[7];
    void'($urandom(32'd7715));
    defs = '{D_ODD_LINES, D_EVEN_LINES, D_ODD_VEND, D_EVEN_VEND, D_ODD_XFER, D_EVEN_XFER, D_DRAIN};
    m_cnt = 1; m_fld = 0; m_step = 0; m_h1 = 0; m_prev_s = 0; m_hi = 0;
    for (int k = 0; k < 7; k++) begin
      m_act[k] = defs[k];
      m_lo[k]  = defs[k] & 255;
      m_hi     = m_hi | ((defs[k] >> 8) << k);
    end
    rst_n = 1'b0; line_strobe = 1'b0; hblank = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11: reset state seen at the ports
    chk("R11", "fld after reset", int'(fld), 0);
    chk("R11", "vref on line 1", int'(vref), 1);
    chk("R11", "xfer_line", int'(xfer_line), 0);
    chk("R11", "ofd", int'(ofd), 0);
    chk("R11", "vclk step 0", int'(vclk), 3);
    chk("R11", "h1", int'(h1), 0);
    chk("R11", "h2", int'(h2), 1);

    // R2: writes during the default odd field do not shorten it
    for (int i = 0; i < 5; i++) do_line();
    qw(0, 3); qw(1, 2); qw(7, 0); qw(2, 2); qw(3, 0); qw(4, 3); qw(5, 1); qw(6, 2);
    run_field(n);
    chk("R2", "default odd field remainder", n, D_ODD_LINES - 5);
    run_field(n);
    chk("R1", "even count from address 1", n, 2);
    // R1: bit 0 of address 7 extends the odd count to 257
    qw(0, 1); qw(7, 1);
    run_field(n);
    chk("R2", "odd field before reload", n, 3);
    run_field(n);
    chk("R1", "even field", n, 2);
    qw(0, 0); qw(7, 0); qw(12, 77); qw(9, 3);
    run_field(n);
    chk("R1", "odd count with high bit", n, 257);
    run_field(n);
    chk("R1", "even field after ignored writes", n, 2);
    // R4: a count of 0 gives a one-line field
    run_field(n);
    chk("R4", "zero-count odd field", n, 1);
    qw(15, 5); qw(8, 200);
    run_field(n);
    run_field(n);
    chk("R1", "addresses 8 and up ignored", n, 1);

    // Random configurations across many fields
    for (int f = 0; f < 60; f++) begin
      if (($urandom % 2) == 0) queue_random_cfg();
      run_field(n);
    end
    // R10: long blanking then free run
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b0, 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule